// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the 32-bit bus address for every memory access of an accumulator-style CPU core that runs in 8/16-bit compatibility modes or a wide 32-bit mode. The core's decoder supplies the addressing mode, the operand offset or displacement taken from the instruction stream, the index and stack registers, the current bank and program counter, and the code and data segment bases. The block returns the final address and a code naming the segment it used.

A segment-override prefix decoded ahead of an opcode is held in the block until the core signals the end of that instruction. The prefix can redirect data accesses to the code segment, to segment zero, or to a fixed input/output segment at base 0xFFD00000. Instruction fetches always use the code segment and stack accesses always use segment zero. In wide mode the stack is word aligned, so stack-relative displacements count words and are multiplied by four. In compatibility mode a zero code segment makes the result the plain 24-bit bank:offset form.

Each request is registered: the address appears one clock after the request. The address is the segment base plus the offset, wrapping modulo 2^32.

Top module: `seg_addr_gen`

## Requirements
- R1: During and right after reset, `addr_valid_o` is 0, `addr_o` is 0 and `seg_o` is 0.
- R2: Mode 0 (fetch) gives `cs_base_i + pc_i` (24-bit PC, zero extended) with `seg_o` = 1 (code), in both modes and whatever prefix is held. With a zero code base this equals bank:offset.
- R3: With no prefix held, the data modes 1..5 and 7 use the data base `ds_base_i`, with `seg_o` = 2.
- R4: A held prefix of kind 0 makes the data modes use `cs_base_i`, with `seg_o` = 1.
- R5: A held prefix of kind 1 makes the data modes use base 0, with `seg_o` = 0.
- R6: A held prefix of kind 2 makes the data modes use base 0xFFD00000, with `seg_o` = 3.
- R7: A prefix loaded by `pfx_load_i` takes effect from the next cycle. It stays in force for every access until a cycle with `instr_end_i`, after which no prefix is held. If a load and an instruction end fall in the same cycle, the load wins. Kind 3 means no prefix.
- R8: In wide mode (`wide_i`=1), mode 6 (stack-relative) gives `sp_i + 4*offset_i[7:0]` with base 0 and `seg_o` = 0. Any held prefix has no effect on it.
- R9: In compatibility mode, mode 6 gives `(sp_i[15:0] + offset_i[7:0]) mod 2^16` with base 0 and `seg_o` = 0.
- R10: In wide mode, modes 1,4 add nothing, modes 2,5 add `idx_x_i`, and modes 3,7 add `idx_y_i` to the full 32-bit `offset_i`. The sum and the base addition each wrap modulo 2^32.
- R11: In compatibility mode, modes 1..3 use `{bank_i, offset_i[15:0]}` plus the index, and modes 4,5,7 use `offset_i[23:0]` plus the index. Both sums wrap modulo 2^24 before the base is added.
- R12: `addr_valid_o` equals `req_valid_i` of the previous cycle. The address and segment reflect the inputs of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Address request this cycle |
| mode_i | input | 3 | Addressing mode (0 fetch, 1 abs, 2 abs+X, 3 abs+Y, 4 long, 5 long+X, 6 stack-relative, 7 pointer+Y) |
| wide_i | input | 1 | 1 = 32-bit mode, 0 = compatibility mode |
| offset_i | input | 32 | Operand offset, displacement or fetched pointer |
| idx_x_i | input | 32 | X index register |
| idx_y_i | input | 32 | Y index register |
| sp_i | input | 32 | Stack pointer |
| bank_i | input | 8 | Data bank used by compatibility absolute modes |
| pc_i | input | 24 | Program counter offset |
| cs_base_i | input | 32 | Code segment base |
| ds_base_i | input | 32 | Data segment base |
| pfx_load_i | input | 1 | Segment prefix decoded this cycle |
| pfx_kind_i | input | 2 | Prefix kind (0 code, 1 zero, 2 I/O, 3 none) |
| instr_end_i | input | 1 | Current instruction completes this cycle |
| addr_valid_o | output | 1 | Registered address is valid |
| addr_o | output | 32 | Final bus address |
| seg_o | output | 2 | Segment used (0 zero, 1 code, 2 data, 3 I/O) |

## Verification
The hardest case to reach is a prefix that has to survive several accesses of one instruction and then vanish at the right edge. The worst form of this is a load and an instruction end in the same cycle. The bench builds these sequences directly. It issues a prefix with no request, performs two data accesses, and then ends the instruction with and without a simultaneous reload. It also places a stack access and a fetch while a prefix is held, to show that those modes ignore it. A randomized phase then mixes prefix loads, instruction ends and all modes, and it includes offsets near the 2^24 and 2^32 wrap points.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    typedef enum logic [2:0] {
        AM_FETCH  = 3'd0,
        AM_ABS    = 3'd1,
        AM_ABS_X  = 3'd2,
        AM_ABS_Y  = 3'd3,
        AM_LONG   = 3'd4,
        AM_LONG_X = 3'd5,
        AM_STK    = 3'd6,
        AM_PTR_Y  = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        SEG_ZERO = 2'd0,
        SEG_CODE = 2'd1,
        SEG_DATA = 2'd2,
        SEG_IO   = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        PFX_CODE = 2'd0,
        PFX_ZERO = 2'd1,
        PFX_IO   = 2'd2,
        PFX_NONE = 2'd3
    } pfx_e;

endpackage

// File: rtl/seg_pfx_hold.sv
module seg_pfx_hold
    import seg_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pfx_load_i,
    input  logic [1:0] pfx_kind_i,
    input  logic       instr_end_i,
    output pfx_e       pfx_o
);

    typedef struct packed {
        pfx_e kind;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (instr_end_i) begin
            st_d.kind = PFX_NONE;
        end
        if (pfx_load_i) begin
            st_d.kind = pfx_e'(pfx_kind_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.kind <= PFX_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pfx_o = st_q.kind;

    // R7
    pfx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end_i && !pfx_load_i) |=> (pfx_o == PFX_NONE));

    // R7
    pfx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_load_i |=> (pfx_o == pfx_e'($past(pfx_kind_i))));

    // R7
    pfx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pfx_load_i && !instr_end_i) |=> $stable(pfx_o));

endmodule

// File: rtl/seg_offset_calc.sv
module seg_offset_calc
    import seg_addr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int PC_W     = 24,
    parameter int BANK_W   = 8,
    parameter int SHORT_W  = 16,
    parameter int DISP_W   = 8,
    parameter int SR_SHIFT = 2
) (
    input  logic              wide_i,
    input  am_e               mode_i,
    input  logic [AW-1:0]     offset_i,
    input  logic [AW-1:0]     x_i,
    input  logic [AW-1:0]     y_i,
    input  logic [AW-1:0]     sp_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [AW-1:0]     off_o
);

    localparam int LONG_W = BANK_W + SHORT_W;

    logic [AW-1:0]      idx;
    logic [LONG_W-1:0]  emu_abs;
    logic [LONG_W-1:0]  emu_long;
    logic [SHORT_W-1:0] emu_stk;
    logic [AW-1:0]      disp_sc;
    logic [AW-1:0]      wide_stk;
    logic [AW-1:0]      wide_lin;

    always_comb begin
        unique case (mode_i)
            AM_ABS_X, AM_LONG_X: idx = x_i;
            AM_ABS_Y, AM_PTR_Y:  idx = y_i;
            default:             idx = '0;
        endcase

        emu_abs  = {bank_i, offset_i[SHORT_W-1:0]} + idx[LONG_W-1:0];
        emu_long = offset_i[LONG_W-1:0] + idx[LONG_W-1:0];
        emu_stk  = sp_i[SHORT_W-1:0] + SHORT_W'(offset_i[DISP_W-1:0]);
        disp_sc  = AW'(offset_i[DISP_W-1:0]) << SR_SHIFT;
        wide_stk = sp_i + disp_sc;
        wide_lin = offset_i + idx;

        unique case (mode_i)
            AM_FETCH:                   off_o = AW'(pc_i);
            AM_STK:                     off_o = wide_i ? wide_stk : AW'(emu_stk);
            AM_ABS, AM_ABS_X, AM_ABS_Y: off_o = wide_i ? wide_lin : AW'(emu_abs);
            default:                    off_o = wide_i ? wide_lin : AW'(emu_long);
        endcase
    end

endmodule

// File: rtl/seg_base_sel.sv
module seg_base_sel
    import seg_addr_pkg::*;
#(
    parameter int          AW      = 32,
    parameter logic [31:0] IO_BASE = 32'hFFD0_0000
) (
    input  am_e           mode_i,
    input  pfx_e          pfx_i,
    input  logic [AW-1:0] cs_i,
    input  logic [AW-1:0] ds_i,
    output seg_e          seg_o,
    output logic [AW-1:0] base_o
);

    always_comb begin
        unique case (mode_i)
            AM_FETCH: seg_o = SEG_CODE;
            AM_STK:   seg_o = SEG_ZERO;
            default: begin
                unique case (pfx_i)
                    PFX_CODE: seg_o = SEG_CODE;
                    PFX_ZERO: seg_o = SEG_ZERO;
                    PFX_IO:   seg_o = SEG_IO;
                    default:  seg_o = SEG_DATA;
                endcase
            end
        endcase

        unique case (seg_o)
            SEG_CODE: base_o = cs_i;
            SEG_DATA: base_o = ds_i;
            SEG_IO:   base_o = AW'(IO_BASE);
            default:  base_o = '0;
        endcase
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          PC_W     = 24,
    parameter int          BANK_W   = 8,
    parameter int          SHORT_W  = 16,
    parameter int          DISP_W   = 8,
    parameter int          SR_SHIFT = 2,
    parameter logic [31:0] IO_BASE  = 32'hFFD0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [2:0]        mode_i,
    input  logic              wide_i,
    input  logic [AW-1:0]     offset_i,
    input  logic [AW-1:0]     idx_x_i,
    input  logic [AW-1:0]     idx_y_i,
    input  logic [AW-1:0]     sp_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [AW-1:0]     cs_base_i,
    input  logic [AW-1:0]     ds_base_i,
    input  logic              pfx_load_i,
    input  logic [1:0]        pfx_kind_i,
    input  logic              instr_end_i,
    output logic              addr_valid_o,
    output logic [AW-1:0]     addr_o,
    output logic [1:0]        seg_o
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        seg_e          seg;
    } out_t;

    am_e           mode;
    pfx_e          pfx_held;
    logic [AW-1:0] off_w;
    logic [AW-1:0] base_w;
    seg_e          seg_w;
    out_t          out_d, out_q;

    assign mode = am_e'(mode_i);

    seg_pfx_hold u_pfx (
        .clk         (clk),
        .rst_n       (rst_n),
        .pfx_load_i  (pfx_load_i),
        .pfx_kind_i  (pfx_kind_i),
        .instr_end_i (instr_end_i),
        .pfx_o       (pfx_held)
    );

    seg_offset_calc #(
        .AW       (AW),
        .PC_W     (PC_W),
        .BANK_W   (BANK_W),
        .SHORT_W  (SHORT_W),
        .DISP_W   (DISP_W),
        .SR_SHIFT (SR_SHIFT)
    ) u_off (
        .wide_i   (wide_i),
        .mode_i   (mode),
        .offset_i (offset_i),
        .x_i      (idx_x_i),
        .y_i      (idx_y_i),
        .sp_i     (sp_i),
        .bank_i   (bank_i),
        .pc_i     (pc_i),
        .off_o    (off_w)
    );

    seg_base_sel #(
        .AW      (AW),
        .IO_BASE (IO_BASE)
    ) u_base (
        .mode_i (mode),
        .pfx_i  (pfx_held),
        .cs_i   (cs_base_i),
        .ds_i   (ds_base_i),
        .seg_o  (seg_w),
        .base_o (base_w)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = req_valid_i;
        if (req_valid_i) begin
            out_d.addr = base_w + off_w;
            out_d.seg  = seg_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.valid <= 1'b0;
            out_q.addr  <= '0;
            out_q.seg   <= SEG_ZERO;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_valid_o = out_q.valid;
    assign addr_o       = out_q.addr;
    assign seg_o        = out_q.seg;

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> addr_valid_o);

    // R12
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !addr_valid_o);

    // R2
    fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mode == AM_FETCH) |=>
        (seg_o == SEG_CODE && addr_o == $past(cs_base_i) + AW'($past(pc_i))));

    // R8
    stack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mode == AM_STK) |=>
        (seg_o == SEG_ZERO && addr_o == $past(off_w)));

    // R6
    io_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && pfx_held == PFX_IO && mode != AM_FETCH && mode != AM_STK) |=>
        (seg_o == SEG_IO && addr_o == $past(off_w) + AW'(IO_BASE)));

endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid_i;
    logic [2:0]  mode_i;
    logic        wide_i;
    logic [31:0] offset_i, idx_x_i, idx_y_i, sp_i, cs_base_i, ds_base_i;
    logic [7:0]  bank_i;
    logic [23:0] pc_i;
    logic        pfx_load_i;
    logic [1:0]  pfx_kind_i;
    logic        instr_end_i;
    logic        addr_valid_o;
    logic [31:0] addr_o;
    logic [1:0]  seg_o;

    always #10 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .mode_i(mode_i),
        .wide_i(wide_i), .offset_i(offset_i), .idx_x_i(idx_x_i), .idx_y_i(idx_y_i),
        .sp_i(sp_i), .bank_i(bank_i), .pc_i(pc_i), .cs_base_i(cs_base_i),
        .ds_base_i(ds_base_i), .pfx_load_i(pfx_load_i), .pfx_kind_i(pfx_kind_i),
        .instr_end_i(instr_end_i), .addr_valid_o(addr_valid_o), .addr_o(addr_o),
        .seg_o(seg_o)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // staging values for the next cycle
    logic        s_req, s_wide, s_load, s_end;
    int          s_mode, s_kind;
    logic [31:0] s_off, s_x, s_y, s_sp, s_cs, s_ds;
    logic [7:0]  s_bank;
    logic [23:0] s_pc;

    // reference model state
    int          m_pfx = 3;
    bit          pend = 0;
    logic        e_valid;
    logic [31:0] e_addr;
    int          e_seg;
    string       e_tag;

    function automatic longint idx_of(int mode, longint x, longint y);
        if (mode == 2 || mode == 5) return x;
        if (mode == 3 || mode == 7) return y;
        return 0;
    endfunction

    task automatic model(output logic [31:0] addr, output int seg, output string tag);
        longint o, b, ix;
        ix = idx_of(s_mode, longint'(s_x), longint'(s_y));
        if (s_mode == 0) o = longint'(s_pc);
        else if (s_mode == 6) begin
            if (s_wide) o = (longint'(s_sp) + longint'(s_off[7:0]) * 4) % 64'h1_0000_0000;
            else        o = (longint'(s_sp[15:0]) + longint'(s_off[7:0])) % 65536;
        end else if (s_wide) o = (longint'(s_off) + ix) % 64'h1_0000_0000;
        else if (s_mode <= 3) o = (longint'(s_bank) * 65536 + longint'(s_off[15:0]) + ix) % 64'h100_0000;
        else o = (longint'(s_off[23:0]) + ix) % 64'h100_0000;

        if (s_mode == 0)      begin seg = 1; tag = "R2"; end
        else if (s_mode == 6) begin seg = 0; tag = s_wide ? "R8" : "R9"; end
        else begin
            case (m_pfx)
                0: begin seg = 1; tag = "R4"; end
                1: begin seg = 0; tag = "R5"; end
                2: begin seg = 3; tag = "R6"; end
                default: begin seg = 2; tag = s_wide ? "R10" : "R11"; end
            endcase
        end
        case (seg)
            1: b = longint'(s_cs);
            2: b = longint'(s_ds);
            3: b = 64'hFFD0_0000;
            default: b = 0;
        endcase
        addr = 32'((b + o) % 64'h1_0000_0000);
    endtask

    task automatic check_pending();
        if (!pend) return;
        tests++;
        if (addr_valid_o !== e_valid) begin
            fails++;
            $display("FAIL R12 valid actual %0b expected %0b", addr_valid_o, e_valid);
        end else if (e_valid) begin
            tests++;
            if (addr_o !== e_addr || int'(seg_o) != e_seg) begin
                fails++;
                $display("FAIL %s addr/seg actual %h/%0d expected %h/%0d",
                         e_tag, addr_o, seg_o, e_addr, e_seg);
            end
        end
    endtask

    task automatic tick(input string tag_over);
        @(negedge clk);
        check_pending();
        req_valid_i = s_req;  mode_i = 3'(s_mode); wide_i = s_wide;
        offset_i = s_off; idx_x_i = s_x; idx_y_i = s_y; sp_i = s_sp;
        bank_i = s_bank; pc_i = s_pc; cs_base_i = s_cs; ds_base_i = s_ds;
        pfx_load_i = s_load; pfx_kind_i = 2'(s_kind); instr_end_i = s_end;
        e_valid = s_req;
        model(e_addr, e_seg, e_tag);
        if (tag_over != "") e_tag = tag_over;
        pend = 1;
        if (s_end) m_pfx = 3;
        if (s_load) m_pfx = s_kind;
    endtask

    task automatic idle_stage();
        s_req = 0; s_load = 0; s_end = 0; s_kind = 3; s_mode = 1;
    endtask

    // R7 helpers: access with a given mode
    task automatic acc(input int mode, input logic [31:0] off, input string tag);
        s_req = 1; s_mode = mode; s_off = off; s_load = 0; s_end = 0;
        tick(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 0;
        req_valid_i = 0; mode_i = 0; wide_i = 0; offset_i = 0; idx_x_i = 0;
        idx_y_i = 0; sp_i = 0; bank_i = 0; pc_i = 0; cs_base_i = 0; ds_base_i = 0;
        pfx_load_i = 0; pfx_kind_i = 3; instr_end_i = 0;
        idle_stage();
        s_wide = 0; s_off = 0; s_x = 0; s_y = 0; s_sp = 0; s_bank = 0; s_pc = 0;
        s_cs = 0; s_ds = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (addr_valid_o !== 1'b0 || addr_o !== 32'h0 || seg_o !== 2'd0) begin
            fails++;
            $display("FAIL R1 reset actual %b/%h/%0d expected 0/0/0", addr_valid_o, addr_o, seg_o);
        end
        rst_n = 1;
        @(negedge clk);
        tests++;
        if (addr_valid_o !== 1'b0 || addr_o !== 32'h0 || seg_o !== 2'd0) begin
            fails++;
            $display("FAIL R1 after reset actual %b/%h/%0d expected 0/0/0", addr_valid_o, addr_o, seg_o);
        end

        // R2: compatibility fetch, zero code base -> bank:offset
        s_wide = 0; s_cs = 0; s_pc = 24'h12_3456;
        acc(0, 0, "R2");
        // R2: wide fetch with code base
        s_wide = 1; s_cs = 32'h1000_0000; s_pc = 24'h00_ABCD;
        acc(0, 0, "R2");
        // R3: default data segment
        s_ds = 32'h2000_0000;
        acc(1, 32'h0000_1234, "R3");
        // R4 + R7: code prefix held over two accesses
        idle_stage(); s_load = 1; s_kind = 0; tick("");
        acc(1, 32'h0000_0040, "R4");
        s_x = 32'h8; acc(2, 32'h0000_0040, "R7");
        // R8: prefix held but stack ignores it
        s_sp = 32'h0000_3FFC; acc(6, 32'h3, "R8");
        // R2: fetch ignores held prefix
        acc(0, 0, "R2");
        // R7: end clears
        idle_stage(); s_end = 1; tick("");
        acc(1, 32'h0000_0040, "R7");
        // R5: zero prefix
        s_ds = 32'h5555_0000;
        idle_stage(); s_load = 1; s_kind = 1; tick("");
        acc(4, 32'h0012_3456, "R5");
        // R7: load and end in same cycle, load wins
        idle_stage(); s_load = 1; s_kind = 2; s_end = 1; tick("");
        acc(1, 32'h0000_0020, "R6");
        acc(1, 32'h0000_0020, "R7");
        // R8: IO prefix held, wide stack
        s_sp = 32'h0000_3FFC; acc(6, 32'hFF, "R8");
        idle_stage(); s_end = 1; tick("");
        // R9: compatibility stack wraps at 16 bits
        s_wide = 0; s_sp = 32'hABCD_FFFE; acc(6, 32'h5, "R9");
        // R10: wide wrap modulo 2^32
        s_wide = 1; s_ds = 0; s_x = 32'h20; acc(5, 32'hFFFF_FFF0, "R10");
        s_ds = 32'h8000_0000; acc(4, 32'h9000_0000, "R10");
        s_y = 32'h1_0000; acc(7, 32'h1234_0000, "R10");
        // R11: compatibility abs wraps at 24 bits
        s_wide = 0; s_ds = 0; s_bank = 8'hFF; s_x = 32'h2; acc(2, 32'h7777_FFFF, "R11");
        s_y = 32'h10; acc(3, 32'h0000_8000, "R11");
        s_x = 32'h5; acc(5, 32'hAAFF_FFFE, "R11");
        // R12: idle cycle
        idle_stage(); tick("R12");

        // randomized mix
        for (int i = 0; i < 2000; i++) begin
            s_req  = ($urandom % 4) != 0;
            s_mode = int'($urandom % 8);
            s_wide = ($urandom % 2) != 0;
            s_off  = ($urandom % 4 == 0) ? (32'hFFFF_FF00 | 32'($urandom % 256)) : $urandom;
            s_x = $urandom; s_y = ($urandom % 2 == 0) ? 32'($urandom % 512) : $urandom;
            s_sp = $urandom; s_bank = 8'($urandom); s_pc = 24'($urandom);
            s_cs = ($urandom % 3 == 0) ? 32'h0 : $urandom;
            s_ds = $urandom;
            s_load = ($urandom % 6) == 0;
            s_kind = int'($urandom % 4);
            s_end  = ($urandom % 5) == 0;
            tick("");
        end
        idle_stage(); tick("R12");
        idle_stage(); tick("R12");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule